// File: doc/BRIEF.md
# SPI Slave Hold Controller

This block is the pause logic of a serial flash slave interface. It resynchronises chip enable, the serial clock, serial input data and a shared active-low reset/hold pin into a system clock domain. From these it produces a hold flag and an output-enable for the serial data output. A small receive shifter sits under the same control and takes one bit on every serial clock rise. While hold is in force, the shifter keeps its contents and its bit count, so a transfer resumes exactly where it stopped.

After power-on the shared pin acts as an active-low interface reset. A one-cycle strobe from the command decoder turns it into an active-low hold input. That choice is sticky and is undone only by the power-on reset. Hold entry and exit take effect only while the serial clock is low. A pin edge that arrives while the clock is high is acted on at the next low phase. Raising chip enable during hold drops the block back to standby.

The block has no data stream with flow control. The received byte and the bit count are plain level outputs that the surrounding logic samples.

Top module: `spi_hold_ctrl`

## Requirements
- R1: After power-on the pin is in reset function (`pin_hold_mode` = 0). In that function a low pin level drives `iface_clr` = 1, forces `so_oe` = 0, and clears `rx_data` and `bit_cnt` to 0.
- R2: A one-cycle `en_hold_cmd` pulse sets `pin_hold_mode` to 1. It stays 1 through further pulses and any pin activity, until `por_n` is asserted low.
- R3: While `pin_hold_mode` = 0, `hold_active` never becomes 1.
- R4: In hold function, with `cs_n` low and `sck` low, a falling edge on `hold_rst_n` raises `hold_active` on the third rising edge of `clk` after the change (two synchroniser stages plus the state register).
- R5: If `sck` is high when the pin goes low, hold does not start until `sck` goes low. A low pulse on the pin that lies wholly inside one `sck` high phase causes no hold.
- R6: Hold ends only when the pin is high while `sck` is low. A pin rise during `sck` high takes effect at the next `sck` low.
- R7: `cs_n` high during hold clears `hold_active`, and hold is never entered while `cs_n` is high.
- R8: `so_oe` is 1 exactly when `cs_n` is low, hold is not active and `iface_clr` is 0.
- R9: On each rising `sck` with `cs_n` low and no hold, `si` is shifted into bit 0 of `rx_data`, so the first bit ends up as the MSB. `bit_cnt` counts modulo BITS. A high `cs_n` returns `bit_cnt` to 0 and leaves `rx_data` unchanged.
- R10: During hold, `sck` edges and `si` are ignored, and `rx_data` and `bit_cnt` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| cs_n | input | 1 | Chip enable, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| hold_rst_n | input | 1 | Shared reset/hold pin, active low |
| en_hold_cmd | input | 1 | One-cycle strobe: switch the pin to hold function |
| pin_hold_mode | output | 1 | 1 when the pin acts as hold |
| hold_active | output | 1 | Hold in force |
| so_oe | output | 1 | Serial output drive enable |
| iface_clr | output | 1 | Interface cleared by the pin in reset function |
| rx_data | output | BITS | Received shift register |
| bit_cnt | output | $clog2(BITS) | Bits received in the current word |

## Verification
The bench builds the block with BITS = 8, so all nine pause points of a word, from before the first bit to after the last, are reachable and are swept one by one with a distinct byte each. Entry and exit are each tried with `sck` low and with `sck` high at the pin edge, which covers both the immediate and the deferred path. With the two-flop synchronisers at their default depth the three-cycle entry latency can be pinned to an exact edge.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef enum logic {ST_RUN = 1'b0, ST_PAUSE = 1'b1} hold_st_t;
  localparam int SYNC_STAGES = 2;
endpackage

// File: rtl/hold_sync.sv
module hold_sync #(
  parameter int W = 4,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [hold_pkg::SYNC_STAGES-1:0] pipe;
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) pipe <= {hold_pkg::SYNC_STAGES{INIT[b]}};
      else        pipe <= {pipe[hold_pkg::SYNC_STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = pipe[hold_pkg::SYNC_STAGES-1];
  end
endmodule

// File: rtl/hold_mode_latch.sv
module hold_mode_latch (
  input  logic clk,
  input  logic por_n,
  input  logic set_i,
  output logic mode_o
);
  logic mode_q;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)     mode_q <= 1'b0;
    else if (set_i) mode_q <= 1'b1;
  end
  assign mode_o = mode_q;

  // R2
  mode_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    mode_q |=> mode_q);
endmodule

// File: rtl/hold_fsm.sv
module hold_fsm
  import hold_pkg::*;
(
  input  logic clk,
  input  logic por_n,
  input  logic mode_hold_i,
  input  logic pin_i,
  input  logic sck_i,
  input  logic cs_n_i,
  output logic hold_o
);
  hold_st_t st_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) st_q <= ST_RUN;
    else begin
      case (st_q)
        ST_RUN:
          if (mode_hold_i && !pin_i && !cs_n_i && !sck_i) st_q <= ST_PAUSE;
        ST_PAUSE:
          if (cs_n_i || (pin_i && !sck_i)) st_q <= ST_RUN;
        default: st_q <= ST_RUN;
      endcase
    end
  end
  assign hold_o = (st_q == ST_PAUSE);

  // R3
  no_hold_in_reset_fn_chk: assert property (@(posedge clk) disable iff (!por_n)
    !mode_hold_i |=> !hold_o);
  // R5
  entry_sck_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(hold_o) |-> $past(!sck_i && !cs_n_i));
  // R6
  exit_sck_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(hold_o) |-> $past(cs_n_i || !sck_i));
  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hold_o && cs_n_i) |=> !hold_o);
endmodule

// File: rtl/hold_shifter.sv
module hold_shifter #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            clr_i,
  input  logic            cs_n_i,
  input  logic            hold_i,
  input  logic            sck_i,
  input  logic            si_i,
  output logic [BITS-1:0] data_o,
  output logic [CW-1:0]   cnt_o
);
  logic [BITS-1:0] data_q;
  logic [CW-1:0]   cnt_q;
  logic            sck_prev;
  logic            rise;

  assign rise = sck_i && !sck_prev;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      data_q   <= '0;
      cnt_q    <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck_i;
      if (clr_i) begin
        data_q <= '0;
        cnt_q  <= '0;
      end else if (cs_n_i) begin
        cnt_q <= '0;
      end else if (rise && !hold_i) begin
        data_q <= {data_q[BITS-2:0], si_i};
        cnt_q  <= (cnt_q == CW'(BITS - 1)) ? '0 : cnt_q + CW'(1);
      end
    end
  end
  assign data_o = data_q;
  assign cnt_o  = cnt_q;

  // R10
  frozen_in_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (hold_i && !cs_n_i && !clr_i) |=> ($stable(cnt_q) && $stable(data_q)));
  // R1
  clear_empties_chk: assert property (@(posedge clk) disable iff (!por_n)
    clr_i |=> (cnt_q == '0 && data_q == '0));
endmodule

// File: rtl/spi_hold_ctrl.sv
module spi_hold_ctrl #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            cs_n,
  input  logic            sck,
  input  logic            si,
  input  logic            hold_rst_n,
  input  logic            en_hold_cmd,
  output logic            pin_hold_mode,
  output logic            hold_active,
  output logic            so_oe,
  output logic            iface_clr,
  output logic [BITS-1:0] rx_data,
  output logic [CW-1:0]   bit_cnt
);
  logic [3:0] raw, synced;
  logic cs_s, sck_s, si_s, pin_s;
  logic mode, hold, clr;

  assign raw = {cs_n, sck, si, hold_rst_n};

  hold_sync #(.W(4), .INIT(4'b1001)) u_sync (
    .clk(clk), .por_n(por_n), .d_i(raw), .q_o(synced)
  );
  assign {cs_s, sck_s, si_s, pin_s} = synced;

  hold_mode_latch u_mode (
    .clk(clk), .por_n(por_n), .set_i(en_hold_cmd), .mode_o(mode)
  );

  hold_fsm u_fsm (
    .clk(clk), .por_n(por_n), .mode_hold_i(mode), .pin_i(pin_s),
    .sck_i(sck_s), .cs_n_i(cs_s), .hold_o(hold)
  );

  assign clr = !mode && !pin_s;

  hold_shifter #(.BITS(BITS)) u_shift (
    .clk(clk), .por_n(por_n), .clr_i(clr), .cs_n_i(cs_s), .hold_i(hold),
    .sck_i(sck_s), .si_i(si_s), .data_o(rx_data), .cnt_o(bit_cnt)
  );

  assign pin_hold_mode = mode;
  assign hold_active   = hold;
  assign iface_clr     = clr;
  assign so_oe         = !cs_s && !hold && !clr;

  // R8
  oe_off_in_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    hold_active |-> !so_oe);
endmodule

// File: tb/tb_spi_hold_ctrl.sv
`timescale 1ns/1ps
module tb_spi_hold_ctrl;
  localparam int BITS = 8;
  localparam int CW = $clog2(BITS);

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_rst_n = 1'b1, en_hold_cmd = 1'b0;
  logic pin_hold_mode, hold_active, so_oe, iface_clr;
  logic [BITS-1:0] rx_data;
  logic [CW-1:0]   bit_cnt;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  spi_hold_ctrl #(.BITS(BITS)) dut (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .sck(sck), .si(si),
    .hold_rst_n(hold_rst_n), .en_hold_cmd(en_hold_cmd),
    .pin_hold_mode(pin_hold_mode), .hold_active(hold_active), .so_oe(so_oe),
    .iface_clr(iface_clr), .rx_data(rx_data), .bit_cnt(bit_cnt)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(logic b);
    si = b; sck = 1'b0; wait_n(4);
    sck = 1'b1; wait_n(4);
    sck = 1'b0; wait_n(4);
  endtask

  initial begin
    #800000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    por_n = 1'b1;
    wait_n(5);
    // R1 reset state
    chk("R1 mode", pin_hold_mode, 0);
    chk("R8 oe cs high", so_oe, 0);
    chk("R1 cnt", bit_cnt, 0);
    chk("R1 data", rx_data, 0);

    // R9 basic shift, R1 clear through pin
    cs_n = 1'b0; wait_n(4);
    chk("R8 oe on", so_oe, 1);
    send_bit(1); send_bit(0); send_bit(1);
    chk("R9 cnt 3", bit_cnt, 3);
    chk("R9 data 101", rx_data, 5);
    hold_rst_n = 1'b0; wait_n(4);
    chk("R1 clr", iface_clr, 1);
    chk("R1 oe off", so_oe, 0);
    chk("R1 cnt cleared", bit_cnt, 0);
    chk("R1 data cleared", rx_data, 0);
    chk("R3 no hold", hold_active, 0);
    send_bit(1);
    chk("R1 cnt held at 0", bit_cnt, 0);
    chk("R3 still no hold", hold_active, 0);
    hold_rst_n = 1'b1; wait_n(4);
    chk("R1 clr released", iface_clr, 0);

    // R2 mode switch
    en_hold_cmd = 1'b1; wait_n(1); en_hold_cmd = 1'b0; wait_n(1);
    chk("R2 mode set", pin_hold_mode, 1);
    en_hold_cmd = 1'b1; wait_n(1); en_hold_cmd = 1'b0; wait_n(1);
    chk("R2 mode stays", pin_hold_mode, 1);

    // R4 exact latency
    sck = 1'b0; hold_rst_n = 1'b0;
    wait_n(2);
    chk("R4 not yet", hold_active, 0);
    wait_n(1);
    chk("R4 entered", hold_active, 1);
    chk("R8 oe off in hold", so_oe, 0);
    chk("R1 no clr in hold fn", iface_clr, 0);
    hold_rst_n = 1'b1; wait_n(5);
    chk("R6 exit sck low", hold_active, 0);

    // R5 / R6 deferred paths
    for (int sh = 0; sh < 2; sh++) begin
      sck = logic'(sh); wait_n(4);
      hold_rst_n = 1'b0; wait_n(6);
      chk("R5 entry by sck level", hold_active, sh == 0 ? 1 : 0);
      sck = 1'b0; wait_n(5);
      chk("R5 entry at sck low", hold_active, 1);
      sck = logic'(sh); wait_n(4);
      hold_rst_n = 1'b1; wait_n(6);
      chk("R6 exit by sck level", hold_active, sh == 0 ? 0 : 1);
      sck = 1'b0; wait_n(5);
      chk("R6 exit at sck low", hold_active, 0);
    end
    // R5 glitch inside sck high
    sck = 1'b1; wait_n(4);
    hold_rst_n = 1'b0; wait_n(5);
    hold_rst_n = 1'b1; wait_n(5);
    sck = 1'b0; wait_n(6);
    chk("R5 glitch ignored", hold_active, 0);

    // R7 chip enable release
    hold_rst_n = 1'b0; wait_n(5);
    chk("R7 in hold", hold_active, 1);
    cs_n = 1'b1; wait_n(5);
    chk("R7 standby", hold_active, 0);
    chk("R8 oe off cs high", so_oe, 0);
    wait_n(4);
    chk("R7 no entry with cs high", hold_active, 0);
    hold_rst_n = 1'b1; wait_n(2);
    cs_n = 1'b0; wait_n(5);
    chk("R7 resumed", hold_active, 0);
    chk("R8 oe resumed", so_oe, 1);

    // R9 / R10 pause-point sweep
    for (int k = 0; k <= BITS; k++) begin
      int b;
      b = (k * 37 + 90) & 255;
      cs_n = 1'b1; wait_n(5);
      chk("R9 cs clears cnt", bit_cnt, 0);
      cs_n = 1'b0; wait_n(4);
      for (int i = 0; i < k; i++) send_bit(logic'((b >> (BITS - 1 - i)) & 1));
      hold_rst_n = 1'b0; wait_n(5);
      chk("R10 hold on", hold_active, 1);
      send_bit(~logic'(b & 1)); send_bit(1'b1);
      chk("R10 cnt kept", bit_cnt, k % BITS);
      if (k > 0)
        chk("R10 data kept", int'(rx_data) & ((1 << k) - 1), b >> (BITS - k));
      hold_rst_n = 1'b1; wait_n(5);
      chk("R6 hold off", hold_active, 0);
      for (int i = k; i < BITS; i++) send_bit(logic'((b >> (BITS - 1 - i)) & 1));
      chk("R9 byte", rx_data, b);
      chk("R9 cnt wrap", bit_cnt, 0);
    end
    chk("R2 mode persists", pin_hold_mode, 1);

    // R2 power-on restores reset function
    por_n = 1'b0; wait_n(2); por_n = 1'b1; wait_n(5);
    chk("R2 por restores", pin_hold_mode, 0);
    hold_rst_n = 1'b0; wait_n(5);
    chk("R3 reset fn again", hold_active, 0);
    chk("R1 clr again", iface_clr, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule